// File: doc/BRIEF.md
# Run-Length Pattern Stimulus Source

This block drives a single output bit from a stored pattern. Software-side logic (or a test sequencer) loads the pattern as a list of run entries. Each run holds one bit value and a repeat count. On a start pulse the block expands the runs one time unit at a time, and a `tick` strobe marks each time unit. The expanded pattern can contain up to `DEPTH` runs.

Two playback modes exist, and the mode is latched at start. Cyclic mode loops over the expanded pattern forever, so the period of the output equals the sum of all run counts. For example, runs (3 x 0, 7 x 1) give a 10-unit period that is low for 3 units and high for 7. One-shot mode plays the expanded pattern once and then holds the final value. For example, runs (1 x 1, 2 x 0, 1 x 1) give high, low, low, then high for good.

Top module: `pattern_source`

## Requirements
- R1: While `rst_n` is low and after its release, `out_bit` is 0, `playing` is 0 and the stored pattern is empty.
- R2: A run entry carries its value in bit 0 and its repeat count in bits 15:1. During playback each run shows its value for exactly `count` time units, in load order.
- R3: A `start` pulse with a non-empty pattern sets `out_bit` to the first run's value and `playing` to 1 in the next cycle, which is unit 1. The block advances one unit per cycle in which `tick` is high.
- R4: In cyclic mode (`mode_cyclic`=1 at start) the expansion wraps from its last unit back to unit 1 without a gap. The period equals the sum of run counts, and `playing` stays 1.
- R5: In one-shot mode (`mode_cyclic`=0 at start), the tick after the last unit clears `playing`, and `out_bit` then holds the last run's value whatever ticks follow.
- R6: A write whose count field is zero is rejected and adds no run.
- R7: Writes are ignored while `playing` is 1. Writes past `DEPTH` runs are ignored.
- R8: `ld_clear` empties the pattern. A `start` with an empty pattern drives `out_bit` low and leaves `playing` at 0.
- R9: `stop` clears `playing`, and `out_bit` keeps its value. A later `start` replays from unit 1.
- R10: `out_bit` changes only in the cycle after a `tick` or a `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle time-unit strobe |
| mode_cyclic | input | 1 | 1 = loop forever, 0 = play once and hold; sampled at start |
| start | input | 1 | Begin playback from unit 1 |
| stop | input | 1 | Halt playback, holding the output |
| ld_we | input | 1 | Append one run entry (idle only) |
| ld_data | input | 16 | Run entry: [15:1] count, [0] value |
| ld_clear | input | 1 | Empty the stored pattern (idle only) |
| out_bit | output | 1 | Registered stimulus output |
| playing | output | 1 | High while the pattern is being stepped |

## Verification
If the run index or the remaining-unit counter goes wrong, `out_bit` shows it at the next run boundary. It also shows when it should not: a cyclic pattern fails to come back to unit 1 exactly one period later. A fault in the stored length appears in two places. In cyclic mode the period shifts, which shows up within one period of the expanded pattern. In one-shot mode `playing` falls on the wrong tick. A stuck or skipped write shows up as a missing or extra run on the first replay after loading.

// File: rtl/pat_pkg.sv
package pat_pkg;
  localparam int RUN_CNT_W = 15;
  localparam int RUN_W     = RUN_CNT_W + 1;

  typedef struct packed {
    logic [RUN_CNT_W-1:0] count;
    logic                 value;
  } run_t;
endpackage

// File: rtl/pat_store.sv
module pat_store
  import pat_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int LEN_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic             wr_en,
  input  run_t             wr_run,
  input  logic             clear,
  input  logic [IDX_W-1:0] rd_addr,
  output run_t             rd_run,
  output logic [LEN_W-1:0] length
);
  run_t             mem [DEPTH];
  logic [LEN_W-1:0] len_q, len_n;
  logic             accept;

  always_comb begin
    accept = !busy && wr_en && !clear && (wr_run.count != '0)
             && (len_q != LEN_W'(DEPTH));
    len_n  = len_q;
    if (!busy && clear) len_n = '0;
    else if (accept)    len_n = len_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) len_q <= '0;
    else        len_q <= len_n;
  end

  always_ff @(posedge clk) begin
    if (accept) mem[len_q[IDX_W-1:0]] <= wr_run;
  end

  assign rd_run = mem[rd_addr];
  assign length = len_q;

  // R7
  len_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    len_q <= LEN_W'(DEPTH));
  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(len_q));
  // R6
  zero_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clear && wr_run.count == '0) |=> $stable(len_q));
endmodule

// File: rtl/pat_player.sv
module pat_player
  import pat_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int LEN_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             mode_cyclic,
  input  logic             start,
  input  logic             stop,
  input  logic [LEN_W-1:0] length,
  input  run_t             rd_run,
  output logic [IDX_W-1:0] rd_addr,
  output logic             out_bit,
  output logic             playing
);
  logic                 play_q, play_n;
  logic                 cyc_q, cyc_n;
  logic [IDX_W-1:0]     idx_q, idx_n;
  logic [RUN_CNT_W-1:0] rem_q, rem_n;
  logic                 out_q, out_n;
  logic [LEN_W-1:0]     idx_inc;
  logic                 last_run;

  assign idx_inc  = {1'b0, idx_q} + 1'b1;
  assign last_run = (idx_inc == length);

  always_comb begin
    if (start || last_run) rd_addr = '0;
    else                   rd_addr = idx_inc[IDX_W-1:0];
  end

  always_comb begin
    play_n = play_q;
    cyc_n  = cyc_q;
    idx_n  = idx_q;
    rem_n  = rem_q;
    out_n  = out_q;
    if (start) begin
      if (length == '0) begin
        play_n = 1'b0;
        out_n  = 1'b0;
      end else begin
        play_n = 1'b1;
        cyc_n  = mode_cyclic;
        idx_n  = '0;
        rem_n  = rd_run.count;
        out_n  = rd_run.value;
      end
    end else if (stop) begin
      play_n = 1'b0;
    end else if (play_q && tick) begin
      if (rem_q > RUN_CNT_W'(1)) begin
        rem_n = rem_q - 1'b1;
      end else if (!last_run || cyc_q) begin
        idx_n = rd_addr;
        rem_n = rd_run.count;
        out_n = rd_run.value;
      end else begin
        play_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      play_q <= 1'b0;
      cyc_q  <= 1'b0;
      idx_q  <= '0;
      rem_q  <= '0;
      out_q  <= 1'b0;
    end else begin
      play_q <= play_n;
      cyc_q  <= cyc_n;
      idx_q  <= idx_n;
      rem_q  <= rem_n;
      out_q  <= out_n;
    end
  end

  assign out_bit = out_q;
  assign playing = play_q;

  // R10
  out_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !start) |=> $stable(out_q));
  // R2
  rem_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    play_q |-> (rem_q != '0));
  // R2
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    play_q |-> ({1'b0, idx_q} < length));
  // R4
  cyc_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (play_q && cyc_q && !start && !stop) |=> play_q);
  // R9
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !start) |=> (!play_q && $stable(out_q)));
endmodule

// File: rtl/pattern_source.sv
module pattern_source
  import pat_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              mode_cyclic,
  input  logic              start,
  input  logic              stop,
  input  logic              ld_we,
  input  logic [RUN_W-1:0]  ld_data,
  input  logic              ld_clear,
  output logic              out_bit,
  output logic              playing
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int LEN_W = IDX_W + 1;

  logic [IDX_W-1:0] rd_addr;
  run_t             rd_run;
  logic [LEN_W-1:0] length;

  pat_store #(.DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (playing),
    .wr_en   (ld_we),
    .wr_run  (run_t'(ld_data)),
    .clear   (ld_clear),
    .rd_addr (rd_addr),
    .rd_run  (rd_run),
    .length  (length)
  );

  pat_player #(.DEPTH(DEPTH)) u_player (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .mode_cyclic (mode_cyclic),
    .start       (start),
    .stop        (stop),
    .length      (length),
    .rd_run      (rd_run),
    .rd_addr     (rd_addr),
    .out_bit     (out_bit),
    .playing     (playing)
  );
endmodule

// File: tb/sim_pattern_source.sv
`timescale 1ns/1ps
module sim_pattern_source;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, mode_cyclic = 1'b0, start = 1'b0, stop = 1'b0;
  logic ld_we = 1'b0, ld_clear = 1'b0;
  logic [15:0] ld_data = '0;
  logic out_bit, playing;

  int checks = 0, fails = 0;
  int m_cnt [0:299];
  bit m_val [0:299];
  int m_nr = 0;
  int unit = 0;
  bit m_cyc = 1'b0;

  always #2 clk = ~clk;

  pattern_source #(.DEPTH(256)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode_cyclic(mode_cyclic),
    .start(start), .stop(stop), .ld_we(ld_we), .ld_data(ld_data),
    .ld_clear(ld_clear), .out_bit(out_bit), .playing(playing)
  );

  function automatic int total_len();
    int s = 0;
    for (int i = 0; i < m_nr; i++) s += m_cnt[i];
    return s;
  endfunction

  function automatic bit exp_val(int u);
    int L = total_len();
    int k;
    if (m_nr == 0) return 1'b0;
    k = u;
    if (u > L) k = m_cyc ? ((u - 1) % L) + 1 : L;
    for (int i = 0; i < m_nr; i++) begin
      if (k <= m_cnt[i]) return m_val[i];
      k -= m_cnt[i];
    end
    return m_val[m_nr-1];
  endfunction

  function automatic bit exp_play(int u);
    if (m_nr == 0) return 1'b0;
    return m_cyc ? 1'b1 : (u <= total_len());
  endfunction

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s unit=%0d actual=%b expected=%b", req, unit, act, exp);
    end
  endtask

  task automatic wr_run(int cnt, bit v);
    ld_data = {cnt[14:0], v};
    ld_we = 1'b1;
    @(negedge clk);
    ld_we = 1'b0;
    if (!playing_snapshot && cnt != 0 && m_nr < 256) begin
      m_cnt[m_nr] = cnt;
      m_val[m_nr] = v;
      m_nr++;
    end
  endtask

  bit playing_snapshot = 1'b0;

  task automatic clear_pat();
    ld_clear = 1'b1;
    @(negedge clk);
    ld_clear = 1'b0;
    m_nr = 0;
  endtask

  task automatic do_start(bit cyc, string req);
    mode_cyclic = cyc;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    m_cyc = cyc;
    unit = 1;
    chk(req, out_bit, exp_val(1));
    chk(req, playing, exp_play(1));
  endtask

  task automatic step(bit tk, string req);
    logic prev;
    prev = out_bit;
    tick = tk;
    @(negedge clk);
    tick = 1'b0;
    if (tk) begin
      unit++;
      chk(req, out_bit, exp_val(unit));
    end else begin
      chk("R10", out_bit, prev);
    end
    chk(req, playing, exp_play(unit));
  endtask

  task automatic do_stop();
    logic prev;
    prev = out_bit;
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk("R9", playing, 1'b0);
    chk("R9", out_bit, prev);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog unit=%0d actual=timeout expected=done", unit);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", out_bit, 1'b0);
    chk("R1", playing, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", out_bit, 1'b0);
    chk("R1", playing, 1'b0);

    // R8: empty pattern start drives low
    do_start(1'b1, "R8");

    // R2 R4: 3x0 then 7x1, period 10
    wr_run(3, 1'b0); wr_run(7, 1'b1);
    do_start(1'b1, "R3");
    for (int i = 0; i < 35; i++) step(1'b1, "R4");
    do_stop();

    // R4: 4x1, 2x0, 1x1, period 7, random tick gaps
    clear_pat();
    wr_run(4, 1'b1); wr_run(2, 1'b0); wr_run(1, 1'b1);
    do_start(1'b1, "R3");
    for (int i = 0; i < 40; i++) step(1'($urandom_range(0, 1)), "R4");
    do_stop();

    // R5: 1x1, 2x0, 1x1 once then hold high
    clear_pat();
    wr_run(1, 1'b1); wr_run(2, 1'b0); wr_run(1, 1'b1);
    do_start(1'b0, "R5");
    for (int i = 0; i < 10; i++) step(1'b1, "R5");

    // R6: zero-count entry skipped
    clear_pat();
    wr_run(2, 1'b1); wr_run(0, 1'b0); wr_run(3, 1'b0);
    do_start(1'b1, "R6");
    for (int i = 0; i < 12; i++) step(1'b1, "R6");

    // R7: writes while playing ignored
    playing_snapshot = 1'b1;
    wr_run(5, 1'b1);
    playing_snapshot = 1'b0;
    for (int i = 0; i < 6; i++) step(1'b1, "R7");
    do_stop();
    // R9: replay from unit 1 after stop
    do_start(1'b1, "R9");
    for (int i = 0; i < 6; i++) step(1'b1, "R7");
    do_stop();

    // R7: depth cap, 256 alternating runs plus one extra
    clear_pat();
    for (int i = 0; i < 256; i++) wr_run(1, 1'(~i[0]));
    wr_run(1, 1'b1);
    do_start(1'b1, "R7");
    for (int i = 0; i < 300; i++) step(1'b1, "R7");
    do_stop();

    // R2 R4 R5: random patterns
    for (int p = 0; p < 20; p++) begin
      bit cyc;
      int nr;
      clear_pat();
      nr = $urandom_range(1, 8);
      for (int i = 0; i < nr; i++)
        wr_run($urandom_range(1, 5), 1'($urandom_range(0, 1)));
      cyc = 1'($urandom_range(0, 1));
      do_start(cyc, cyc ? "R4" : "R5");
      for (int i = 0; i < 60; i++)
        step(1'($urandom_range(0, 3) != 0), cyc ? "R4" : "R2");
      if (playing) do_stop();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule